// File: doc/BRIEF.md
# Linked Context-ID Breakpoint Checker

This block decides whether a breakpoint slot that another debug comparator links to is currently satisfied. It keeps a bank of breakpoint slots, each with a control register and a value register, loaded through a simple one-cycle register-write port. A query names a slot by its link number. The block checks that number against the range of context-aware slots given by a configuration word. It then looks at the slot's enable bit and breakpoint type, and compares the slot's value against the current context identifier at the current privilege level.

The answer is registered. It appears with a valid strobe one clock after the query is presented. A separate combinational error output flags a configuration word that declares more context-aware comparators than breakpoints.

Top module: `ctxlink_checker`

## Requirements
- R1: After reset every slot's control and value registers are zero, so every slot is disabled; `link_valid` and `link_ok` are low while reset is asserted.
- R2: The configuration word holds each count as the number of items minus one: bits 27:24 give the breakpoint count and bits 23:20 give the context-aware comparator count.
- R3: A link number greater than the breakpoint count field never satisfies the link.
- R4: When the context count does not exceed the breakpoint count, a link number below (breakpoint count minus context count) never satisfies the link. When it does exceed it, there is no lower bound.
- R5: Bit 0 of a slot's control register is its enable. A slot with this bit clear never satisfies the link.
- R6: Control register bits 23:20 hold the breakpoint type. Type 3 is satisfied when the whole 32-bit context identifier equals bits 31:0 of the slot's value register; bits 63:32 of the value register have no effect.
- R7: A type-3 slot never satisfies the link while the privilege level is 2 or 3.
- R8: Every type other than 3, including 5, 9 and 11, never satisfies the link.
- R9: `link_valid` is high exactly one cycle after a cycle with `query_valid` high. `link_ok` is low whenever `link_valid` is low.
- R10: `cfg_err` is high, in the same cycle, whenever the context count field exceeds the breakpoint count field.
- R11: A write with `wr_sel` = 0 loads the control register and `wr_sel` = 1 loads the value register of slot `wr_slot`. A query presented in the cycle after the write sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the value register |
| wr_slot | input | 4 | Slot index to write |
| wr_data | input | 64 | Write data |
| cfg_word | input | 32 | Configuration word holding the breakpoint and context counts |
| cur_pl | input | 2 | Current privilege level |
| cur_ctx | input | 32 | Current context identifier |
| query_valid | input | 1 | A query is presented this cycle |
| query_link | input | 4 | Link number of the queried slot |
| link_ok | output | 1 | Registered result: linked slot satisfied |
| link_valid | output | 1 | Registered strobe qualifying `link_ok` |
| cfg_err | output | 1 | Combinational flag for an inconsistent configuration word |

## Verification
`link_ok` and `link_valid` are due at the first rising edge after the query inputs are driven. `cfg_err` is due as soon as `cfg_word` settles. The bench drives every input on a falling edge. It reads `cfg_err` 1 ns later in the same half cycle. It reads `link_ok` and `link_valid` on the next falling edge, one register stage later. A register write is driven one falling edge ahead of the query that depends on it, so the write has taken effect at the edge that samples that query.

// File: rtl/ctxlink_pkg.sv
package ctxlink_pkg;
   // configuration word field positions (counts stored as N-1)
   localparam int CFG_CNT_W    = 4;
   localparam int CFG_BP_LSB   = 24;
   localparam int CFG_CTX_LSB  = 20;
   // control register layout
   localparam int CTL_EN_BIT   = 0;
   localparam int CTL_TYPE_LSB = 20;
   localparam int CTL_TYPE_W   = 4;
   // highest privilege level at which context matching may fire
   localparam int CTX_MAX_PL   = 1;

   typedef enum logic [CTL_TYPE_W-1:0] {
      BKT_CTX_LINKED      = 4'd3,
      BKT_MISMATCH_LINKED = 4'd5,
      BKT_VMID_LINKED     = 4'd9,
      BKT_CTX_VMID_LINKED = 4'd11
   } bk_type_e;
endpackage

// File: rtl/bp_slot_bank.sv
module bp_slot_bank #(
   parameter int NUM_SLOTS = 16,
   parameter int LINK_W    = 4,
   parameter int CTRL_W    = 32,
   parameter int VAL_W     = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [LINK_W-1:0] wr_slot,
   input  logic [VAL_W-1:0]  wr_data,
   input  logic [LINK_W-1:0] rd_slot,
   output logic [CTRL_W-1:0] rd_ctrl,
   output logic [VAL_W-1:0]  rd_val
);
   logic [CTRL_W-1:0] ctrl_q [NUM_SLOTS];
   logic [VAL_W-1:0]  val_q  [NUM_SLOTS];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_q[s] <= '0;
            val_q[s]  <= '0;
         end else if (wr_en && (wr_slot == LINK_W'(s))) begin
            if (wr_sel) val_q[s]  <= wr_data;
            else        ctrl_q[s] <= wr_data[CTRL_W-1:0];
         end
      end
   end

   if (NUM_SLOTS == (1 << LINK_W)) begin : g_full_rd
      assign rd_ctrl = ctrl_q[rd_slot];
      assign rd_val  = val_q[rd_slot];
   end else begin : g_part_rd
      always_comb begin
         rd_ctrl = '0;
         rd_val  = '0;
         for (int s = 0; s < NUM_SLOTS; s++) begin
            if (rd_slot == LINK_W'(s)) begin
               rd_ctrl = ctrl_q[s];
               rd_val  = val_q[s];
            end
         end
      end
   end

   if (VAL_W > CTRL_W) begin : g_unused
      logic unused_wr_hi;
      assign unused_wr_hi = ^wr_data[VAL_W-1:CTRL_W];
   end
endmodule

// File: rtl/link_range_check.sv
module link_range_check
   import ctxlink_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int LINK_W    = 4
) (
   input  logic [31:0]       cfg_word,
   input  logic [LINK_W-1:0] link,
   output logic              in_range,
   output logic              cfg_err
);
   localparam int EXT_W = CFG_CNT_W + 1;

   logic [EXT_W-1:0] bp_x, ctx_x, floor_x, link_x;
   logic             upper_ok, lower_ok, slot_ok;

   assign bp_x    = {1'b0, cfg_word[CFG_BP_LSB  +: CFG_CNT_W]};
   assign ctx_x   = {1'b0, cfg_word[CFG_CTX_LSB +: CFG_CNT_W]};
   assign link_x  = EXT_W'(link);
   assign cfg_err = ctx_x > bp_x;
   assign floor_x = bp_x - ctx_x;

   assign upper_ok = link_x <= bp_x;
   // a negative floor (inconsistent config) imposes no lower limit
   assign lower_ok = cfg_err || (link_x >= floor_x);

   if (NUM_SLOTS == (1 << LINK_W)) begin : g_all_slots
      assign slot_ok = 1'b1;
   end else begin : g_some_slots
      assign slot_ok = link_x < EXT_W'(NUM_SLOTS);
   end

   assign in_range = upper_ok && lower_ok && slot_ok;

   logic unused_cfg;
   assign unused_cfg = ^{cfg_word[31:CFG_BP_LSB+CFG_CNT_W], cfg_word[CFG_CTX_LSB-1:0]};
endmodule

// File: rtl/ctx_match_eval.sv
module ctx_match_eval
   import ctxlink_pkg::*;
#(
   parameter int CTRL_W = 32,
   parameter int VAL_W  = 64,
   parameter int CTX_W  = 32
) (
   input  logic [CTRL_W-1:0] ctrl,
   input  logic [VAL_W-1:0]  val,
   input  logic [1:0]        pl,
   input  logic [CTX_W-1:0]  ctx,
   output logic              match
);
   logic [CTL_TYPE_W-1:0] bkt;
   logic                  enabled, pl_ok;

   assign enabled = ctrl[CTL_EN_BIT];
   assign bkt     = ctrl[CTL_TYPE_LSB +: CTL_TYPE_W];
   assign pl_ok   = int'(pl) <= CTX_MAX_PL;

   always_comb begin
      match = 1'b0;
      if (enabled) begin
         case (bkt)
            BKT_CTX_LINKED: match = pl_ok && (val[CTX_W-1:0] == ctx);
            // mismatch, VMID and reserved or unlinked types never fire
            default:        match = 1'b0;
         endcase
      end
   end

   logic unused_bits;
   assign unused_bits = ^{ctrl[CTRL_W-1:CTL_TYPE_LSB+CTL_TYPE_W],
                          ctrl[CTL_TYPE_LSB-1:CTL_EN_BIT+1],
                          val[VAL_W-1:CTX_W]};
endmodule

// File: rtl/ctxlink_checker.sv
module ctxlink_checker
   import ctxlink_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int CTRL_W    = 32,
   parameter int VAL_W     = 64,
   parameter int CTX_W     = 32,
   localparam int LINK_W   = CFG_CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [LINK_W-1:0] wr_slot,
   input  logic [VAL_W-1:0]  wr_data,
   input  logic [31:0]       cfg_word,
   input  logic [1:0]        cur_pl,
   input  logic [CTX_W-1:0]  cur_ctx,
   input  logic              query_valid,
   input  logic [LINK_W-1:0] query_link,
   output logic              link_ok,
   output logic              link_valid,
   output logic              cfg_err
);
   if (NUM_SLOTS < 1 || NUM_SLOTS > (1 << LINK_W)) begin : g_bad_slots
      $error("NUM_SLOTS must lie in 1..16");
   end
   if (CTRL_W < CTL_TYPE_LSB + CTL_TYPE_W + 1 || CTRL_W > VAL_W) begin : g_bad_ctrl
      $error("CTRL_W must hold the type field and fit in VAL_W");
   end
   if (CTX_W >= VAL_W) begin : g_bad_ctx
      $error("CTX_W must be narrower than VAL_W");
   end

   logic [CTRL_W-1:0] sel_ctrl;
   logic [VAL_W-1:0]  sel_val;
   logic              in_range, ctx_hit;

   bp_slot_bank #(
      .NUM_SLOTS(NUM_SLOTS), .LINK_W(LINK_W), .CTRL_W(CTRL_W), .VAL_W(VAL_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_slot(wr_slot), .wr_data(wr_data),
      .rd_slot(query_link), .rd_ctrl(sel_ctrl), .rd_val(sel_val)
   );

   link_range_check #(
      .NUM_SLOTS(NUM_SLOTS), .LINK_W(LINK_W)
   ) u_range (
      .cfg_word(cfg_word), .link(query_link),
      .in_range(in_range), .cfg_err(cfg_err)
   );

   ctx_match_eval #(
      .CTRL_W(CTRL_W), .VAL_W(VAL_W), .CTX_W(CTX_W)
   ) u_eval (
      .ctrl(sel_ctrl), .val(sel_val), .pl(cur_pl), .ctx(cur_ctx), .match(ctx_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_valid <= 1'b0;
         link_ok    <= 1'b0;
      end else begin
         link_valid <= query_valid;
         link_ok    <= query_valid && in_range && ctx_hit;
      end
   end
endmodule

// File: rtl/ctxlink_checker_sva.sv
module ctxlink_checker_sva #(
   parameter int LINK_W = 4,
   parameter int CTX_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       cfg_word,
   input logic [1:0]        cur_pl,
   input logic              query_valid,
   input logic [LINK_W-1:0] query_link,
   input logic              link_ok,
   input logic              link_valid,
   input logic              cfg_err
);
   logic [4:0] link_x, bp_x, ctx_x;
   assign link_x = 5'(query_link);
   assign bp_x   = {1'b0, cfg_word[27:24]};
   assign ctx_x  = {1'b0, cfg_word[23:20]};

   assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      query_valid |=> link_valid);
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !query_valid |=> (!link_valid && !link_ok));
   assert_ok_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
      link_ok |-> link_valid);
   assert_high_pl_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (query_valid && cur_pl > 2'd1) |=> !link_ok);
   assert_above_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (query_valid && link_x > bp_x) |=> !link_ok);
   assert_below_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (query_valid && !cfg_err && link_x < (bp_x - ctx_x)) |=> !link_ok);
   assert_err_nonzero_ctx_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (ctx_x != 5'd0));
endmodule

bind ctxlink_checker ctxlink_checker_sva #(.LINK_W(LINK_W), .CTX_W(CTX_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cur_pl(cur_pl),
   .query_valid(query_valid), .query_link(query_link),
   .link_ok(link_ok), .link_valid(link_valid), .cfg_err(cfg_err)
);

// File: tb/ctxlink_checker_bench.sv
`timescale 1ns/1ps
module ctxlink_checker_bench;
   localparam real PERIOD = 20.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_sel = 1'b0;
   logic [3:0]  wr_slot = '0;
   logic [63:0] wr_data = '0;
   logic [31:0] cfg_word = '0;
   logic [1:0]  cur_pl = '0;
   logic [31:0] cur_ctx = '0;
   logic        query_valid = 1'b0;
   logic [3:0]  query_link = '0;
   logic        link_ok, link_valid, cfg_err;

   int checks = 0, failures = 0;
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   ctxlink_checker u_ctxlink_checker (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_slot(wr_slot),
      .wr_data(wr_data), .cfg_word(cfg_word), .cur_pl(cur_pl), .cur_ctx(cur_ctx),
      .query_valid(query_valid), .query_link(query_link),
      .link_ok(link_ok), .link_valid(link_valid), .cfg_err(cfg_err)
   );

   // vector: {bp_cnt, ctx_cnt, link, pl, ctx_id, expected link_ok}
   localparam int NV = 16;
   localparam logic [46:0] VEC [NV] = '{
      {4'd15, 4'd5, 4'd10, 2'd0, 32'h12345678, 1'b1},  // R6 match, upper value bits ignored
      {4'd15, 4'd5, 4'd10, 2'd1, 32'h12345678, 1'b1},  // R7 level 1 allowed
      {4'd15, 4'd5, 4'd10, 2'd2, 32'h12345678, 1'b0},  // R7
      {4'd15, 4'd5, 4'd10, 2'd3, 32'h12345678, 1'b0},  // R7
      {4'd15, 4'd5, 4'd10, 2'd0, 32'h12345679, 1'b0},  // R6 mismatch
      {4'd15, 4'd5, 4'd11, 2'd0, 32'h12345678, 1'b0},  // R5 disabled
      {4'd15, 4'd5, 4'd12, 2'd0, 32'h12345678, 1'b0},  // R8 type 5
      {4'd15, 4'd5, 4'd13, 2'd0, 32'h12345678, 1'b0},  // R8 type 9
      {4'd15, 4'd5, 4'd14, 2'd0, 32'h12345678, 1'b0},  // R8 type 11
      {4'd15, 4'd5, 4'd15, 2'd0, 32'hCAFE0001, 1'b1},  // R6 top slot
      {4'd15, 4'd5, 4'd9,  2'd0, 32'h12345678, 1'b0},  // R4 below floor
      {4'd15, 4'd6, 4'd9,  2'd0, 32'h12345678, 1'b1},  // R4 at floor
      {4'd8,  4'd0, 4'd9,  2'd0, 32'h12345678, 1'b0},  // R3 above count
      {4'd9,  4'd0, 4'd9,  2'd0, 32'h12345678, 1'b1},  // R3/R4 link equals count
      {4'd2,  4'd0, 4'd2,  2'd0, 32'h12345678, 1'b1},  // R2 small config
      {4'd2,  4'd5, 4'd2,  2'd0, 32'h12345678, 1'b1}   // R10 inconsistent, no floor
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic sel, input logic [3:0] slot, input logic [63:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_slot = slot; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic query(input logic [3:0] bp, input logic [3:0] cc, input logic [3:0] lk,
                        input logic [1:0] pl, input logic [31:0] cid, input logic exp,
                        input string req);
      @(negedge clk);
      cfg_word = {4'h0, bp, cc, 20'h0};
      query_link = lk; cur_pl = pl; cur_ctx = cid; query_valid = 1'b1;
      #1;
      chk("R10 cfg_err", 64'(cfg_err), 64'(cc > bp));
      @(negedge clk);
      chk("R9 link_valid", 64'(link_valid), 64'd1);
      chk(req, 64'(link_ok), 64'(exp));
      query_valid = 1'b0;
   endtask

   function automatic logic [63:0] ctl(input logic [3:0] t, input logic en);
      return {40'h0, t, 19'h0, en};
   endfunction

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 link_valid in reset", 64'(link_valid), 64'd0);
      chk("R1 link_ok in reset", 64'(link_ok), 64'd0);
      rst_n = 1'b1;
      // zeroed bank: slot 0 value 0 equals context 0, yet must not fire
      query(4'd15, 4'd15, 4'd0, 2'd0, 32'h0, 1'b0, "R1 zeroed slot");

      write_reg(1'b0, 4'd10, ctl(4'd3, 1'b1));
      write_reg(1'b1, 4'd10, 64'hFFFF_FFFF_1234_5678);
      write_reg(1'b0, 4'd11, ctl(4'd3, 1'b0));
      write_reg(1'b1, 4'd11, 64'h1234_5678);
      write_reg(1'b0, 4'd12, ctl(4'd5, 1'b1));
      write_reg(1'b1, 4'd12, 64'h1234_5678);
      write_reg(1'b0, 4'd13, ctl(4'd9, 1'b1));
      write_reg(1'b1, 4'd13, 64'h1234_5678);
      write_reg(1'b0, 4'd14, ctl(4'd11, 1'b1));
      write_reg(1'b1, 4'd14, 64'h1234_5678);
      write_reg(1'b0, 4'd15, ctl(4'd3, 1'b1));
      write_reg(1'b1, 4'd15, 64'hCAFE_0001);
      write_reg(1'b0, 4'd9, ctl(4'd3, 1'b1));
      write_reg(1'b1, 4'd9, 64'h1234_5678);
      write_reg(1'b0, 4'd2, ctl(4'd3, 1'b1));
      write_reg(1'b1, 4'd2, 64'h1234_5678);

      for (int i = 0; i < NV; i++) begin
         query(VEC[i][46:43], VEC[i][42:39], VEC[i][38:35], VEC[i][34:33],
               VEC[i][32:1], VEC[i][0], $sformatf("R6 vector %0d link_ok", i));
      end

      // R9: idle cycle gives no strobe and no result
      @(negedge clk);
      query_valid = 1'b0;
      @(negedge clk);
      chk("R9 idle link_valid", 64'(link_valid), 64'd0);
      chk("R9 idle link_ok", 64'(link_ok), 64'd0);

      // R11: write then query on the next cycle
      write_reg(1'b0, 4'd3, ctl(4'd3, 1'b1));
      write_reg(1'b1, 4'd3, 64'h0000_0000_A5A5_A5A5);
      query(4'd3, 4'd3, 4'd3, 2'd0, 32'hA5A5A5A5, 1'b1, "R11 fresh write");
      // R5: clearing the enable stops matching
      write_reg(1'b0, 4'd3, ctl(4'd3, 1'b0));
      query(4'd3, 4'd3, 4'd3, 2'd0, 32'hA5A5A5A5, 1'b0, "R5 enable cleared");
      // R11: value select targets value register only; control unchanged
      write_reg(1'b0, 4'd3, ctl(4'd3, 1'b1));
      write_reg(1'b1, 4'd3, 64'h5A5A5A5A);
      query(4'd3, 4'd3, 4'd3, 2'd0, 32'h5A5A5A5A, 1'b1, "R11 value rewrite");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule